// File: doc/BRIEF.md
# Grid Scan and Brightness Timer

This block drives the grid (digit) lines of a multiplexed dot-matrix fluorescent display. It enables one grid at a time, steps through a programmable number of digit positions, and passes the current digit index to the segment path so that the matching pattern is presented on the anodes. Inside each digit slot a programmable on-time sets the brightness. A short forced-dark gap at the end of every slot keeps ghost images from one digit off the next.

Two configuration registers feed the block: a 4-bit digit-count code and a 10-bit duty value. Code 0 selects all sixteen grids, and any other code k selects grids 1 through k. The duty value gives the number of slot clocks for which the grid is lit, so 0 is dark and 1023 is the brightest setting. Both values are captured only at a digit boundary, so a slot never runs with mixed settings. Reset clears both captured values to 0.

Top module: `grid_scan`

## Requirements
- R1: While reset is asserted, and for the first slot after reset, `grid_o` is all zero, `blank_o` is 1 and `digit_o` is 0. The captured duty and count are both 0 during this slot.
- R2: A digit slot lasts 2**DUTY_W + BLANK_CYC clocks. `digit_o` changes only on the first clock of a new slot.
- R3: Within a slot, the grid is lit while the slot phase (0 at slot start) is below the captured duty. `blank_o` is the inverse of "any grid lit". A captured duty of 0 keeps every grid dark.
- R4: The last BLANK_CYC clocks of every slot are always dark, even at maximum duty.
- R5: With captured count code 0, `digit_o` steps 0,1,...,15. With code k (1..15) it steps 0..k-1. After the last enabled digit it wraps to 0.
- R6: `grid_o` is one-hot or all zero. When a bit is set it is bit `digit_o`, and `grid_o[i]` drives grid line i+1.
- R7: New `digit_cnt_i` and `duty_i` values take effect from the next slot boundary. The rest of the current slot keeps the old values. If the current index is at or beyond the new last digit, the next slot uses digit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| digit_cnt_i | input | CNT_W | Digit-count code (0 selects all grids) |
| duty_i | input | DUTY_W | On-time per slot, in slot clocks |
| grid_o | output | 2**CNT_W | One-hot grid enables, bit i drives grid line i+1 |
| digit_o | output | CNT_W | Index of the digit being scanned |
| blank_o | output | 1 | High when no grid is lit |

## Verification
The case that is hardest to reach from the ports is a configuration change in the middle of a slot that also shrinks the scan below the current index. Both the old duty (for the rest of that slot) and the forced wrap to digit 0 must then be seen. The bench runs a reduced configuration (4-bit duty, 3-clock gap) so that slots are short. It sweeps every count code against several duty values from reset. It then lowers the count to 2 while digit 2 is mid-slot, and checks every remaining clock of that slot and the slots that follow.

// File: rtl/grid_scan_pkg.sv
package grid_scan_pkg;
  localparam int unsigned DEF_CNT_W   = 4;
  localparam int unsigned DEF_DUTY_W  = 10;
  localparam int unsigned DEF_BLANK   = 8;
endpackage

// File: rtl/gs_slot_timer.sv
module gs_slot_timer #(
  parameter int unsigned DUTY_W    = 10,
  parameter int unsigned BLANK_CYC = 8,
  localparam int unsigned SLOT_LEN = (1 << DUTY_W) + BLANK_CYC,
  localparam int unsigned PH_W     = $clog2(SLOT_LEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            wrap_o
);
  logic [PH_W-1:0] ph_q;

  assign wrap_o  = (ph_q == PH_W'(SLOT_LEN - 1));
  assign phase_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (wrap_o) ph_q <= '0;
    else             ph_q <= ph_q + 1'b1;
  end

  // R2: phase stays in range and restarts after the last slot clock
  a_r2_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q < PH_W'(SLOT_LEN));
  a_r2_phase_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (ph_q == '0));
endmodule

// File: rtl/gs_cfg_shadow.sv
module gs_cfg_shadow #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned DUTY_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DUTY_W-1:0] duty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      duty_o <= '0;
    end else if (load_i) begin
      cnt_o  <= cnt_i;
      duty_o <= duty_i;
    end
  end

  // R7: captured settings move only at a slot boundary
  a_r7_hold_mid_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(cnt_o) && $stable(duty_o)));
endmodule

// File: rtl/gs_digit_seq.sv
module gs_digit_seq #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] next_cnt_i,
  input  logic [CNT_W-1:0] act_cnt_i,
  output logic [CNT_W-1:0] idx_o
);
  logic [CNT_W-1:0] last_next, last_act;

  // code 0 means every grid, so the last index is all ones
  assign last_next = (next_cnt_i == '0) ? '1 : next_cnt_i - 1'b1;
  assign last_act  = (act_cnt_i  == '0) ? '1 : act_cnt_i  - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      idx_o <= '0;
    else if (step_i)
      idx_o <= (idx_o >= last_next) ? '0 : idx_o + 1'b1;
  end

  // R2: index moves only on a boundary
  a_r2_idx_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(idx_o));
  // R5: index never exceeds the last enabled digit
  a_r5_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_o <= last_act);
endmodule

// File: rtl/grid_scan.sv
module grid_scan
  import grid_scan_pkg::*;
#(
  parameter int unsigned CNT_W     = DEF_CNT_W,
  parameter int unsigned DUTY_W    = DEF_DUTY_W,
  parameter int unsigned BLANK_CYC = DEF_BLANK,
  localparam int unsigned NUM_GRIDS = 1 << CNT_W,
  localparam int unsigned SLOT_LEN  = (1 << DUTY_W) + BLANK_CYC,
  localparam int unsigned PH_W      = $clog2(SLOT_LEN)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     digit_cnt_i,
  input  logic [DUTY_W-1:0]    duty_i,
  output logic [NUM_GRIDS-1:0] grid_o,
  output logic [CNT_W-1:0]     digit_o,
  output logic                 blank_o
);
  logic [PH_W-1:0]   phase;
  logic              slot_end;
  logic [CNT_W-1:0]  act_cnt;
  logic [DUTY_W-1:0] act_duty;
  logic              lit;

  gs_slot_timer #(.DUTY_W(DUTY_W), .BLANK_CYC(BLANK_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase),
    .wrap_o  (slot_end)
  );

  gs_cfg_shadow #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (slot_end),
    .cnt_i  (digit_cnt_i),
    .duty_i (duty_i),
    .cnt_o  (act_cnt),
    .duty_o (act_duty)
  );

  gs_digit_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (slot_end),
    .next_cnt_i (digit_cnt_i),
    .act_cnt_i  (act_cnt),
    .idx_o      (digit_o)
  );

  // gap clocks sit above any duty value, so they are dark by the compare
  assign lit = (phase < PH_W'(act_duty));

  for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_grid
    assign grid_o[g] = lit && (digit_o == CNT_W'(g));
  end

  assign blank_o = ~lit;

  // R6: at most one grid, and it is the scanned one
  a_r6_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grid_o));
  a_r6_grid_matches_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grid_o != '0) |-> grid_o[digit_o]);
  // R4: gap clocks are dark
  a_r4_gap_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase >= PH_W'(1 << DUTY_W)) |-> (grid_o == '0 && blank_o));
  // R3: zero duty keeps the display dark
  a_r3_zero_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_duty == '0) |-> (grid_o == '0));
endmodule

// File: tb/grid_scan_bench.sv
module grid_scan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 4;
  localparam int DUTY_W = 4;
  localparam int BLANK  = 3;
  localparam int NG     = 1 << CNT_W;
  localparam int ON_LEN = 1 << DUTY_W;
  localparam int SLOT   = ON_LEN + BLANK;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [CNT_W-1:0]  digit_cnt_i = '0;
  logic [DUTY_W-1:0] duty_i = '0;
  logic [NG-1:0]     grid_o;
  logic [CNT_W-1:0]  digit_o;
  logic              blank_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grid_scan #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .BLANK_CYC(BLANK)) u_grid_scan (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .digit_cnt_i (digit_cnt_i),
    .duty_i      (duty_i),
    .grid_o      (grid_o),
    .digit_o     (digit_o),
    .blank_o     (blank_o)
  );

  // compare outputs against expected index/duty at slot phase ph
  task automatic chk(input int ph, input int e_idx, input int e_duty,
                     input string t_idx, input string t_grid);
    logic [NG-1:0] e_grid;
    bit on;
    on = (ph < e_duty);
    e_grid = on ? (NG'(1) << e_idx) : '0;
    n_chk++;
    if (int'(digit_o) != e_idx) begin
      n_bad++;
      $display("FAIL %s digit_o got %0d exp %0d", t_idx, digit_o, e_idx);
    end
    n_chk++;
    if (grid_o !== e_grid || blank_o !== !on) begin
      n_bad++;
      $display("FAIL %s grid_o/blank_o got %h/%b exp %h/%b", t_grid, grid_o, blank_o, e_grid, !on);
    end
    if (grid_o != '0) begin
      n_chk++;
      if ($countones(grid_o) != 1 || !grid_o[digit_o]) begin
        n_bad++;
        $display("FAIL R6 grid_o got %h exp one-hot at %0d", grid_o, digit_o);
      end
    end
  endtask

  task automatic reset_with(input int cnt, input int duty);
    @(negedge clk);
    rst_ni = 1'b0;
    digit_cnt_i = CNT_W'(cnt);
    duty_i = DUTY_W'(duty);
    @(negedge clk);
    chk(0, 0, 0, "R1", "R1");
    rst_ni = 1'b1;
  endtask

  // after reset, slot 0 runs at count 0 / duty 0; new values from slot 1
  task automatic sweep(input int cnt, input int duty);
    int n;
    n = (cnt == 0) ? NG : cnt;
    reset_with(cnt, duty);
    chk(0, 0, 0, "R1", "R1");
    for (int k = 1; k <= (n + 2) * SLOT; k++) begin
      int s, ph;
      @(negedge clk);
      s = k / SLOT;
      ph = k % SLOT;
      if (s == 0) chk(ph, 0, 0, "R1", "R1");
      else chk(ph, s % n, duty, (ph == 0) ? "R2" : "R5",
               (ph >= ON_LEN) ? "R4" : "R3");
    end
  endtask

  // R7: shrink the scan mid-slot while digit 2 is active
  task automatic mid_change;
    reset_with(3, 5);
    for (int k = 1; k <= 7 * SLOT; k++) begin
      int s, ph;
      @(negedge clk);
      s = k / SLOT;
      ph = k % SLOT;
      if (s == 0) chk(ph, 0, 0, "R1", "R1");
      else if (s <= 2) chk(ph, s % 3, 5, "R7", "R7");
      else chk(ph, (s - 3) % 2, 9, "R7", "R7");
      if (k == 2 * SLOT + 3) begin
        digit_cnt_i = CNT_W'(2);
        duty_i = DUTY_W'(9);
      end
    end
  endtask

  initial begin
    int duties[4] = '{0, 1, 7, 15};
    for (int c = 0; c < NG; c++)
      for (int d = 0; d < 4; d++)
        sweep(c, duties[d]);
    mid_change();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule